// File: doc/BRIEF.md
# UART Bit-Rate and Frame Timing Generator

This block turns three software-written settings (a line-control word, an integer divisor and a fractional divisor) into the timing a UART transmitter and receiver need. It emits a one-cycle oversample tick, 16 per bit period. It decodes the frame shape (data length, stop-bit count, parity mode) and reports a word time in bit periods, for use by a receive-timeout counter. It also reports whether the generator is running.

The reference clock is taken as 24 MHz. One bit period lasts 16 x DIV + 16 + FRAC reference cycles, where DIV is a 16-bit integer divisor and FRAC a 3-bit count of extra cycles. The FRAC extra cycles are spread one apiece over the first FRAC sub-ticks of each bit period, so every bit period has the exact length.

Settings are held in staging registers. They become active only when the staged integer divisor is non-zero. While it is zero, every write leaves the active configuration as it was. Any write to one of the three settings restarts the tick phase.

Top module: `baud_frame_gen`

## Requirements
- R1: After reset the block reports the following: tick 0, running 0, data_bits 8, two_stop 0, parity_mode 0 (none) and word_time 10.
- R2: A write to select 0, 1 or 2 is applied only when the staged divisor after the write is non-zero. The staged divisor is the value last written to select 1, and 0 after reset. Otherwise data_bits, two_stop, parity_mode, word_time, running and the tick spacing all keep their previous values.
- R3: While running, 16 consecutive ticks span exactly 16 x DIV + 16 + FRAC clock cycles. Each tick is high for one cycle. With DIV=155 and FRAC=4 this gives 2500 cycles, which is 9600 baud at 24 MHz.
- R4: Sub-tick i (i = 0..15, counted from a restart) lasts DIV+2 cycles when i < FRAC and DIV+1 cycles otherwise.
- R5: data_bits equals line-control bits [1:0] plus 5.
- R6: two_stop equals line-control bit 2.
- R7: parity_mode is 0 (none) when line-control bit 5 is 0. When bit 5 is 1, parity_mode is 2 (even) if bit 3 is 1 and 1 (odd) if bit 3 is 0.
- R8: word_time equals data_bits + stop bits (1 or 2) + 1. Parity does not count toward it.
- R9: A write to select 0 (line control), 1 (integer divisor) or 2 (fraction) is sampled at clock edge k. That write restarts the tick phase. tick is 0 after edge k, and the first tick appears after edge k + L0, where L0 is the length of sub-tick 0 under the configuration active after edge k.
- R10: A write with select 3 has no effect: the tick phase and all configuration outputs are unchanged.
- R11: running becomes 1 at the first applied configuration and stays 1 afterwards. No tick occurs while running is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for one setting |
| cfg_sel | input | 2 | Setting select: 0 line control, 1 integer divisor, 2 fraction, 3 none |
| cfg_wdata | input | 16 | Write data (divisor uses 16 bits, line control 8, fraction 3) |
| tick | output | 1 | One-cycle oversample tick, 16 per bit period |
| running | output | 1 | Generator has an applied non-zero divisor |
| data_bits | output | 4 | Data bits per frame, 5 to 8 |
| two_stop | output | 1 | 1 for two stop bits |
| parity_mode | output | 2 | 0 none, 1 odd, 2 even |
| word_time | output | 4 | Start + data + stop bits, in bit periods |

## Verification
The hardest case to reach is a staged zero divisor that silently blocks later line-control writes while the generator keeps running under its old settings. The stimulus writes divisor 0 during operation and then a new line-control word. It checks that the frame outputs and the tick spacing stay unchanged until a non-zero divisor is written, at which point that line-control word takes effect. The fractional spreading is checked by timing each of the 16 tick intervals on its own, for fractions 0, 4 and 7. A select-3 write is placed inside a sub-tick to show that the phase is not disturbed.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2
  } parity_e;

  typedef enum logic [1:0] {
    SEL_LINE = 2'd0,
    SEL_IDIV = 2'd1,
    SEL_FDIV = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [3:0] data_bits;
    logic       two_stop;
    parity_e    parity;
    logic [3:0] word_time;
  } frame_t;

endpackage

// File: rtl/baud_frame_decode.sv
module baud_frame_decode
  import baud_gen_pkg::*;
#(
  parameter int LCR_W = 8
) (
  input  logic [LCR_W-1:0] lcr,
  output frame_t           frame
);

  logic unused_lcr_bits;
  assign unused_lcr_bits = ^{lcr[4], lcr[LCR_W-1:6]};

  always_comb begin
    frame.data_bits = {2'b00, lcr[1:0]} + 4'd5;
    frame.two_stop  = lcr[2];
    if (!lcr[5])     frame.parity = PAR_NONE;
    else if (lcr[3]) frame.parity = PAR_EVEN;
    else             frame.parity = PAR_ODD;
    // start bit + data + stop; parity not counted
    frame.word_time = frame.data_bits + (lcr[2] ? 4'd2 : 4'd1) + 4'd1;
  end

endmodule

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
  import baud_gen_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          DIV_W     = 16,
  parameter int          FRAC_W    = 3,
  parameter int          LCR_W     = 8,
  parameter int unsigned RESET_LCR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  cfg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DIV_W-1:0]  act_div,
  output logic [FRAC_W-1:0] act_frac,
  output frame_t            frame,
  output logic              running
);

  logic [LCR_W-1:0]  st_lcr,  nx_lcr;
  logic [DIV_W-1:0]  st_div,  nx_div;
  logic [FRAC_W-1:0] st_frac, nx_frac;
  logic              apply;
  frame_t            nx_frame, rst_frame;

  always_comb begin
    nx_lcr  = st_lcr;
    nx_div  = st_div;
    nx_frac = st_frac;
    if (wr) begin
      case (sel)
        SEL_LINE: nx_lcr  = wdata[LCR_W-1:0];
        SEL_IDIV: nx_div  = wdata[DIV_W-1:0];
        SEL_FDIV: nx_frac = wdata[FRAC_W-1:0];
        default:  ;
      endcase
    end
  end

  assign apply = wr && (sel != SEL_NONE) && (nx_div != '0);

  baud_frame_decode #(.LCR_W(LCR_W)) u_dec_next (
    .lcr   (nx_lcr),
    .frame (nx_frame)
  );

  baud_frame_decode #(.LCR_W(LCR_W)) u_dec_reset (
    .lcr   (LCR_W'(RESET_LCR)),
    .frame (rst_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_lcr   <= LCR_W'(RESET_LCR);
      st_div   <= '0;
      st_frac  <= '0;
      act_div  <= '0;
      act_frac <= '0;
      frame    <= rst_frame;
      running  <= 1'b0;
    end else begin
      st_lcr  <= nx_lcr;
      st_div  <= nx_div;
      st_frac <= nx_frac;
      if (apply) begin
        act_div  <= nx_div;
        act_frac <= nx_frac;
        frame    <= nx_frame;
        running  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W      = 16,
  parameter int FRAC_W     = 3,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div,
  input  logic [FRAC_W-1:0] frac,
  output logic              tick
);

  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt, last;
  logic [SUB_W-1:0] sub, sub_nx;
  logic             extra;

  // first FRAC sub-ticks of a bit period get one extra cycle
  assign extra  = ({{FRAC_W{1'b0}}, sub} < {{SUB_W{1'b0}}, frac});
  assign last   = {1'b0, div} + {{DIV_W{1'b0}}, extra};
  assign sub_nx = (sub == SUB_W'(OVERSAMPLE - 1)) ? '0 : sub + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart || !enable) begin
      cnt  <= '0;
      sub  <= '0;
      tick <= 1'b0;
    end else if (cnt == last) begin
      cnt  <= '0;
      sub  <= sub_nx;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/baud_frame_gen.sv
module baud_frame_gen
  import baud_gen_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          DIV_W      = 16,
  parameter int          FRAC_W     = 3,
  parameter int          LCR_W      = 8,
  parameter int          OVERSAMPLE = 16,
  parameter int unsigned RESET_LCR  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              tick,
  output logic              running,
  output logic [3:0]        data_bits,
  output logic              two_stop,
  output logic [1:0]        parity_mode,
  output logic [3:0]        word_time
);

  cfg_sel_e          sel;
  logic [DIV_W-1:0]  act_div;
  logic [FRAC_W-1:0] act_frac;
  frame_t            frame;
  logic              restart;

  assign sel     = cfg_sel_e'(cfg_sel);
  assign restart = cfg_wr && (sel != SEL_NONE);

  baud_cfg_regs #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W),
    .LCR_W(LCR_W), .RESET_LCR(RESET_LCR)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr       (cfg_wr),
    .sel      (sel),
    .wdata    (cfg_wdata),
    .act_div  (act_div),
    .act_frac (act_frac),
    .frame    (frame),
    .running  (running)
  );

  baud_tick_gen #(
    .DIV_W(DIV_W), .FRAC_W(FRAC_W), .OVERSAMPLE(OVERSAMPLE)
  ) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .enable  (running),
    .div     (act_div),
    .frac    (act_frac),
    .tick    (tick)
  );

  assign data_bits   = frame.data_bits;
  assign two_stop    = frame.two_stop;
  assign parity_mode = frame.parity;
  assign word_time   = frame.word_time;

endmodule

// File: rtl/baud_frame_gen_chk.sv
module baud_frame_gen_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [1:0]        cfg_sel,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              tick,
  input logic              running,
  input logic [3:0]        data_bits,
  input logic              two_stop,
  input logic [1:0]        parity_mode,
  input logic [3:0]        word_time
);

  assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !running |-> !tick);

  assert_keep_running_R11: assert property (@(posedge clk) disable iff (rst)
    running |=> running);

  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_sel != 2'd3) |=> !tick);

  assert_zero_div_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_sel == 2'd1 && cfg_wdata == '0) |=>
      ($stable(data_bits) && $stable(two_stop) && $stable(parity_mode) &&
       $stable(word_time) && $stable(running)));

  assert_sel3_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_sel == 2'd3) |=>
      ($stable(data_bits) && $stable(two_stop) && $stable(parity_mode) &&
       $stable(word_time) && $stable(running)));

  assert_data_range_R5: assert property (@(posedge clk) disable iff (rst)
    (data_bits >= 4'd5) && (data_bits <= 4'd8));

  assert_parity_code_R7: assert property (@(posedge clk) disable iff (rst)
    parity_mode != 2'd3);

  assert_word_sum_R8: assert property (@(posedge clk) disable iff (rst)
    word_time == data_bits + (two_stop ? 4'd2 : 4'd1) + 4'd1);

endmodule

bind baud_frame_gen baud_frame_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_wr      (cfg_wr),
  .cfg_sel     (cfg_sel),
  .cfg_wdata   (cfg_wdata),
  .tick        (tick),
  .running     (running),
  .data_bits   (data_bits),
  .two_stop    (two_stop),
  .parity_mode (parity_mode),
  .word_time   (word_time)
);

// File: tb/sim_baud_frame_gen.sv
module sim_baud_frame_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic        tick, running, two_stop;
  logic [3:0]  data_bits, word_time;
  logic [1:0]  parity_mode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_frame_gen u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tick(tick), .running(running),
    .data_bits(data_bits), .two_stop(two_stop),
    .parity_mode(parity_mode), .word_time(word_time)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the sampling edge
  task automatic wr(logic [1:0] sel, logic [15:0] data);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic chk_frame(int db, int ts, int pm, int wt, int run, string tag);
    chk(data_bits === 4'(db),   {tag, " R5 data_bits"},   data_bits, db);
    chk(two_stop === 1'(ts),    {tag, " R6 two_stop"},    two_stop, ts);
    chk(parity_mode === 2'(pm), {tag, " R7 parity_mode"}, parity_mode, pm);
    chk(word_time === 4'(wt),   {tag, " R8 word_time"},   word_time, wt);
    chk(running === 1'(run),    {tag, " R11 running"},    running, run);
  endtask

  // started right after a restart write: times 16 sub-ticks
  task automatic check_ticks(int dv, int fr, string tag);
    int total = 0;
    chk(tick === 1'b0, {tag, " R9 tick low after restart"}, tick, 0);
    for (int s = 0; s < 16; s++) begin
      int gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (tick !== 1'b1 && gap < dv + 10);
      total += gap;
      if (s == 0)
        chk(gap == dv + 1 + (s < fr ? 1 : 0), {tag, " R9 first tick"}, gap,
            dv + 1 + (s < fr ? 1 : 0));
      else
        chk(gap == dv + 1 + (s < fr ? 1 : 0), {tag, " R4 sub-tick length"}, gap,
            dv + 1 + (s < fr ? 1 : 0));
    end
    chk(total == 16 * dv + 16 + fr, {tag, " R3 bit period"}, total, 16 * dv + 16 + fr);
  endtask

  task automatic t_reset;
    chk(tick === 1'b0, "R1 tick after reset", tick, 0);
    chk_frame(8, 0, 0, 10, 0, "R1 reset");
  endtask

  task automatic t_staged_not_applied;
    int seen = 0;
    wr(2'd0, 16'h002D);
    chk_frame(8, 0, 0, 10, 0, "R2 lcr with zero divisor");
    wr(2'd2, 16'd4);
    wr(2'd1, 16'd0);
    chk_frame(8, 0, 0, 10, 0, "R2 zero divisor write");
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tick === 1'b1) seen++;
    end
    chk(seen == 0, "R11 no tick while stopped", seen, 0);
  endtask

  task automatic t_first_apply;
    wr(2'd1, 16'd3);
    chk_frame(6, 1, 2, 9, 1, "R11 first apply");
    check_ticks(3, 4, "div3 frac4");
  endtask

  task automatic t_line_sweep;
    wr(2'd0, 16'h0028);
    chk_frame(5, 0, 2, 7, 1, "R7 even 5N1");
    check_ticks(3, 4, "lcr restart");
    wr(2'd0, 16'h0023);
    chk_frame(8, 0, 1, 10, 1, "R8 odd parity excluded");
    wr(2'd0, 16'h0007);
    chk_frame(8, 1, 0, 11, 1, "R6 two stop");
    wr(2'd0, 16'h0008);
    chk_frame(5, 0, 0, 7, 1, "R7 bit3 without enable");
    wr(2'd0, 16'h0026);
    chk_frame(7, 1, 1, 10, 1, "R5 seven bits odd");
  endtask

  task automatic t_fraction;
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd0);
    check_ticks(1, 0, "div1 frac0");
    wr(2'd2, 16'd7);
    wr(2'd1, 16'd2);
    check_ticks(2, 7, "div2 frac7");
  endtask

  task automatic t_zero_div_running;
    wr(2'd1, 16'd0);
    chk_frame(7, 1, 1, 10, 1, "R2 zero div while running");
    check_ticks(2, 7, "R2 old timing kept");
    wr(2'd0, 16'h0000);
    chk_frame(7, 1, 1, 10, 1, "R2 lcr blocked by staged zero");
    check_ticks(2, 7, "R2 still old timing");
    wr(2'd1, 16'd2);
    chk_frame(5, 0, 0, 7, 1, "R2 blocked lcr applied later");
    check_ticks(2, 7, "div2 again");
  endtask

  task automatic t_sel3;
    int n = 0;
    wr(2'd0, 16'h0003);
    chk_frame(8, 0, 0, 10, 1, "R10 before");
    @(negedge clk); n++;
    chk(tick === 1'b0, "R10 no early tick", tick, 0);
    cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_wdata = 16'hFFFF;
    @(negedge clk); n++;
    cfg_wr = 1'b0;
    while (tick !== 1'b1 && n < 20) begin
      @(negedge clk); n++;
    end
    chk(n == 4, "R10 tick phase kept", n, 4);
    chk_frame(8, 0, 0, 10, 1, "R10 after");
  endtask

  task automatic t_9600;
    wr(2'd2, 16'd4);
    wr(2'd1, 16'd155);
    check_ticks(155, 4, "R3 9600 baud");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_staged_not_applied();
    t_first_apply();
    t_line_sweep();
    t_fraction();
    t_zero_div_running();
    t_sel3();
    t_9600();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule